// File: doc/BRIEF.md
# Phased Linear Systolic FIR Array

This block is a one-dimensional chain of identical processing cells on a single clock that evaluates a short FIR filter. Each cell holds a pair of sample buffer registers, a latched coefficient, a partial-sum input register and a 40-bit accumulator. Samples travel down the chain through two buffer stages per cell. Partial sums travel one stage per cell. Because of this mismatch in speed, each accumulator meets the correctly delayed sample.

The array does not move data and do arithmetic in the same cycle. A global sequencer repeats a round made of three phases. In the communication phase every cell takes its neighbour's outputs and cell 0 takes one new sample. In the computation phase every cell performs one multiply-accumulate. The control phase lasts one cycle and hands the chain tail's sum to the output register.

The lengths of the communication and computation phases are cycle counts chosen at start. They are sized to the slowest transfer and to the slowest arithmetic step. The host raises start once, then supplies one sample per round, advancing it after each acknowledge pulse. Abort stops the array at any point and clears its state.

Top module: `phased_systolic_fir`

## Requirements
- R1: After reset, phase_o is 0 (idle), and result_valid_o, sample_ack_o and result_o are all 0.
- R2: A start pulse in idle begins repeating rounds. Each round runs communication (phase_o=1) for C cycles, then computation (phase_o=2) for P cycles, then control (phase_o=3) for 1 cycle. C and P are comm_len_i and comp_len_i, and a value of 0 is taken as 1. A round therefore lasts C+P+1 cycles.
- R3: sample_ack_o is high for exactly the last communication cycle of each round. The array captures sample_i at the end of that cycle.
- R4: Number the samples k from 0 after start and treat any earlier sample as 0. Result k is then sum over j=0..3 of c_j*x[k-j], as a 40-bit signed value, where c_j is coef_i[16j+15:16j] (signed) as captured at start.
- R5: The first 3 rounds after start produce no valid result. From round 3 onward, result_valid_o pulses for one cycle in every round. The pulse comes 2 cycles after the computation phase begins, plus P-1 further cycles, that is P+2 cycles after the sample_ack_o cycle. Round n delivers result n-3.
- R6: When abort_i is high on a clock edge, the array is idle in the following cycle with result_valid_o low, and it gives no further acknowledges. A run that starts later has no memory of earlier samples.
- R7: start_i while a run is active has no effect on the round timing or on the results.
- R8: comm_len_i and comp_len_i are used only when the run starts. Changing them during a run has no effect.
- R9: Full-scale operands (-32768 and 32767 in every coefficient and sample) give exact sums with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run from idle; latches lengths and coefficients |
| abort_i | input | 1 | Stop and clear the array |
| comm_len_i | input | 8 | Communication phase length in cycles (0 means 1) |
| comp_len_i | input | 8 | Computation phase length in cycles (0 means 1) |
| coef_i | input | 64 | Four signed 16-bit coefficients, cell j at bits 16j+15:16j |
| sample_i | input | 16 | Signed sample, captured in the last communication cycle |
| sample_ack_o | output | 1 | Marks the cycle in which sample_i is taken |
| result_o | output | 40 | Signed filter result |
| result_valid_o | output | 1 | One-cycle pulse when result_o is new |
| phase_o | output | 2 | 0 idle, 1 communication, 2 computation, 3 control |

## Verification
The hardest case to reach is an abort that lands in the middle of a computation phase after the chain has filled. At that point every accumulator and buffer holds data that would corrupt the next run if any of it survived. The stimulus polls phase_o until it reads 2, asserts abort on that cycle, and then starts a new run with a different sample set. Any residue from the old run then shows up as a wrong value among the early results. Start pulses and length changes are also applied in the middle of a run, while round spacing and result timing are measured from every acknowledge.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_COMM = 2'd1,
    PH_COMP = 2'd2,
    PH_CTRL = 2'd3
  } phase_e;
endpackage

// File: rtl/sfa_sequencer.sv
module sfa_sequencer
  import sfa_pkg::*;
#(
  parameter int LW    = 8,
  parameter int CELLS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [LW-1:0] comm_len_i,
  input  logic [LW-1:0] comp_len_i,
  output phase_e        phase_o,
  output logic          load_o,
  output logic          clear_o,
  output logic          shift_o,
  output logic          calc_o,
  output logic          ctrl_o,
  output logic          full_o
);
  localparam int RW = $clog2(CELLS) + 1;
  localparam logic [RW-1:0] FILL = RW'(CELLS - 1);

  phase_e        state_q;
  logic [LW-1:0] cnt_q, comm_q, comp_q;
  logic [RW-1:0] rounds_q;

  function automatic logic [LW-1:0] len_m1(input logic [LW-1:0] len);
    return (len == '0) ? '0 : len - LW'(1);
  endfunction

  assign load_o  = (state_q == PH_IDLE) && start_i && !abort_i;
  assign clear_o = abort_i || load_o;
  assign shift_o = (state_q == PH_COMM) && (cnt_q == '0) && !abort_i;
  assign calc_o  = (state_q == PH_COMP) && (cnt_q == '0) && !abort_i;
  assign ctrl_o  = (state_q == PH_CTRL) && !abort_i;
  assign full_o  = (rounds_q == FILL);
  assign phase_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= PH_IDLE;
      cnt_q    <= '0;
      comm_q   <= '0;
      comp_q   <= '0;
      rounds_q <= '0;
    end else if (abort_i) begin
      state_q  <= PH_IDLE;
      cnt_q    <= '0;
      rounds_q <= '0;
    end else begin
      unique case (state_q)
        PH_IDLE: if (start_i) begin
          state_q  <= PH_COMM;
          comm_q   <= len_m1(comm_len_i);
          comp_q   <= len_m1(comp_len_i);
          cnt_q    <= len_m1(comm_len_i);
          rounds_q <= '0;
        end
        PH_COMM: if (cnt_q == '0) begin
          state_q <= PH_COMP;
          cnt_q   <= comp_q;
        end else begin
          cnt_q <= cnt_q - LW'(1);
        end
        PH_COMP: if (cnt_q == '0) begin
          state_q <= PH_CTRL;
        end else begin
          cnt_q <= cnt_q - LW'(1);
        end
        PH_CTRL: begin
          state_q <= PH_COMM;
          cnt_q   <= comm_q;
          if (rounds_q != FILL) rounds_q <= rounds_q + RW'(1);
        end
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  // R2
  ctrl_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_CTRL) |=> (state_q != PH_CTRL));
  // R2
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({shift_o, calc_o, ctrl_o}));
  // R6
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (state_q == PH_IDLE));
  // R7
  restart_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q != PH_IDLE) && start_i && !abort_i) |=> (state_q != PH_IDLE));
endmodule

// File: rtl/sfa_cell.sv
module sfa_cell #(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 load_i,
  input  logic                 shift_i,
  input  logic                 calc_i,
  input  logic signed [DW-1:0] coef_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [AW-1:0] ps_i,
  output logic signed [DW-1:0] x_o,
  output logic signed [AW-1:0] ps_o
);
  logic signed [DW-1:0]   coef_q, xa_q, xb_q;
  logic signed [AW-1:0]   psin_q, acc_q;
  logic signed [2*DW-1:0] mul;
  logic signed [AW-1:0]   prod;

  assign mul  = coef_q * xa_q;
  assign prod = {{(AW-2*DW){mul[2*DW-1]}}, mul};
  assign x_o  = xb_q;
  assign ps_o = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_q <= '0;
      xa_q   <= '0;
      xb_q   <= '0;
      psin_q <= '0;
      acc_q  <= '0;
    end else if (clear_i) begin
      if (load_i) coef_q <= coef_i;
      xa_q   <= '0;
      xb_q   <= '0;
      psin_q <= '0;
      acc_q  <= '0;
    end else begin
      // samples advance two stages per cell, partial sums one
      if (shift_i) begin
        xa_q   <= x_i;
        xb_q   <= xa_q;
        psin_q <= ps_i;
      end
      if (calc_i) acc_q <= psin_q + prod;
    end
  end

  // R6
  acc_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc_q == '0 && xa_q == '0));
  // R4
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!calc_i && !clear_i) |=> $stable(acc_q));
endmodule

// File: rtl/sfa_drain.sv
module sfa_drain #(
  parameter int AW = 40
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 ctrl_i,
  input  logic                 full_i,
  input  logic signed [AW-1:0] acc_i,
  output logic signed [AW-1:0] result_o,
  output logic                 valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else if (clear_i) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else if (ctrl_i) begin
      result_o <= acc_i;
      valid_o  <= full_i;
    end else begin
      valid_o <= 1'b0;
    end
  end

  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R6
  abort_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !valid_o);
endmodule

// File: rtl/phased_systolic_fir.sv
module phased_systolic_fir
  import sfa_pkg::*;
#(
  parameter int CELLS = 4,
  parameter int DW    = 16,
  parameter int AW    = 40,
  parameter int LW    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                abort_i,
  input  logic [LW-1:0]       comm_len_i,
  input  logic [LW-1:0]       comp_len_i,
  input  logic [CELLS*DW-1:0] coef_i,
  input  logic [DW-1:0]       sample_i,
  output logic                sample_ack_o,
  output logic [AW-1:0]       result_o,
  output logic                result_valid_o,
  output logic [1:0]          phase_o
);
  phase_e phase;
  logic   load, clear, shift, calc, ctrl, full;

  logic signed [DW-1:0] x_chain  [CELLS+1];
  logic signed [AW-1:0] ps_chain [CELLS+1];
  logic signed [AW-1:0] res_s;

  sfa_sequencer #(.LW(LW), .CELLS(CELLS)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .abort_i    (abort_i),
    .comm_len_i (comm_len_i),
    .comp_len_i (comp_len_i),
    .phase_o    (phase),
    .load_o     (load),
    .clear_o    (clear),
    .shift_o    (shift),
    .calc_o     (calc),
    .ctrl_o     (ctrl),
    .full_o     (full)
  );

  assign x_chain[0]  = sample_i;
  assign ps_chain[0] = '0;

  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    sfa_cell #(.DW(DW), .AW(AW)) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear),
      .load_i  (load),
      .shift_i (shift),
      .calc_i  (calc),
      .coef_i  (coef_i[g*DW +: DW]),
      .x_i     (x_chain[g]),
      .ps_i    (ps_chain[g]),
      .x_o     (x_chain[g+1]),
      .ps_o    (ps_chain[g+1])
    );
  end

  sfa_drain #(.AW(AW)) u_drain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear),
    .ctrl_i   (ctrl),
    .full_i   (full),
    .acc_i    (ps_chain[CELLS]),
    .result_o (res_s),
    .valid_o  (result_valid_o)
  );

  assign result_o     = res_s;
  assign sample_ack_o = shift;
  assign phase_o      = phase;

  // R3
  ack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_ack_o |=> !sample_ack_o);
  // R3
  ack_in_comm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_ack_o |-> (phase_o == 2'd1));
endmodule

// File: tb/phased_systolic_fir_tb.sv
`timescale 1ns/1ps
module phased_systolic_fir_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, abort_i = 1'b0;
  logic [7:0]  comm_len_i = 8'd1, comp_len_i = 8'd1;
  logic [63:0] coef_i = '0;
  logic [15:0] sample_i = '0;
  logic        sample_ack_o, result_valid_o;
  logic [39:0] result_o;
  logic [1:0]  phase_o;

  phased_systolic_fir u_dut (.*);

  always #4 clk_i = ~clk_i;

  int pass_n = 0, fail_n = 0;
  int cyc = 0;
  logic signed [15:0] samp [0:63];
  int    cf [4];
  longint expq[$];
  int idx = 0, pops = 0, acks = 0;
  bit ack_pend = 0, have_prev = 0;
  int last_ack = 0, exp_c = 1, exp_p = 1;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    if (ok) pass_n++;
    else begin
      fail_n++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_y(input int m);
    longint s = 0;
    for (int j = 0; j < 4; j++)
      if (m - j >= 0) s += longint'(cf[j]) * longint'(samp[m-j]);
    return s;
  endfunction

  // monitor: feeds samples, pushes expected results, compares output
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (ack_pend) begin
        idx++;
        sample_i = (idx < 64) ? samp[idx] : 16'sd0;
        ack_pend = 0;
      end
      if (result_valid_o) begin
        if (expq.size() == 0) chk(0, "R5 valid before fill", 1, 0);
        else begin
          automatic longint e = expq.pop_front();
          automatic longint a = longint'($signed(result_o));
          chk(a == e, "R4 result value", a, e);
          chk(cyc == last_ack + exp_p + 2, "R5 valid timing", cyc - last_ack, exp_p + 2);
          pops++;
        end
      end
      if (sample_ack_o) begin
        if (have_prev) chk(cyc - last_ack == exp_c + exp_p + 1, "R2 round period",
                           cyc - last_ack, exp_c + exp_p + 1);
        last_ack = cyc;
        have_prev = 1;
        acks++;
        if (idx >= 3) expq.push_back(exp_y(idx - 3));
        ack_pend = 1;
      end
    end
  end

  always @(posedge clk_i) if (cyc > 100000) begin
    fail_n++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end

  task automatic start_run(input int c, input int p);
    comm_len_i = 8'(c);
    comp_len_i = 8'(p);
    for (int j = 0; j < 4; j++) coef_i[16*j +: 16] = 16'(cf[j]);
    exp_c = (c == 0) ? 1 : c;
    exp_p = (p == 0) ? 1 : p;
    @(negedge clk_i);
    idx = 0; have_prev = 0; pops = 0; ack_pend = 0;
    sample_i = samp[0];
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    chk(phase_o == 2'd1, "R2 comm after start", phase_o, 1);
  endtask

  task automatic finish_run(input int k);
    int a0;
    while (idx < k) @(negedge clk_i);
    do @(negedge clk_i); while (!result_valid_o);
    abort_i = 1;
    @(negedge clk_i);
    abort_i = 0;
    chk(phase_o == 2'd0, "R6 idle after abort", phase_o, 0);
    chk(!result_valid_o, "R6 valid low after abort", result_valid_o, 0);
    chk(pops >= k - 3, "R5 result count", pops, k - 3);
    a0 = acks;
    repeat (20) @(negedge clk_i);
    chk(acks == a0, "R6 no ack after abort", acks - a0, 0);
    expq.delete();
  endtask

  task automatic fill_lcg(input int seed);
    int s = seed;
    for (int i = 0; i < 64; i++) begin
      s = s * 1103515245 + 12345;
      samp[i] = 16'(s >>> 11);
    end
  endtask

  initial begin
    int mism;
    for (int i = 0; i < 64; i++) samp[i] = 0;
    repeat (3) @(negedge clk_i);
    // R1
    chk(phase_o == 2'd0, "R1 phase reset", phase_o, 0);
    chk(!result_valid_o, "R1 valid reset", result_valid_o, 0);
    chk(!sample_ack_o, "R1 ack reset", sample_ack_o, 0);
    chk(result_o == '0, "R1 result reset", result_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // impulse, shortest phases
    cf = '{3, -2, 5, 1};
    samp[0] = 1;
    start_run(1, 1);
    finish_run(10);

    // pseudo-random, phase sequence checked
    cf = '{1200, -700, 31, -9000};
    fill_lcg(7);
    start_run(3, 2);
    mism = 0;
    for (int i = 1; i < 3; i++) begin @(negedge clk_i); if (phase_o != 2'd1) mism++; end
    for (int i = 0; i < 2; i++) begin @(negedge clk_i); if (phase_o != 2'd2) mism++; end
    @(negedge clk_i); if (phase_o != 2'd3) mism++;
    @(negedge clk_i); if (phase_o != 2'd1) mism++;
    chk(mism == 0, "R2 phase order", mism, 0);
    finish_run(20);

    // R9 full scale, zero lengths taken as one (R2)
    cf = '{-32768, -32768, 32767, -32768};
    for (int i = 0; i < 64; i++) samp[i] = (i % 3 == 2) ? 16'sd32767 : -16'sd32768;
    start_run(0, 0);
    finish_run(12);

    // R7 start while running, R8 length change while running
    cf = '{-5, 77, 300, -1};
    fill_lcg(99);
    start_run(2, 4);
    while (idx < 5) @(negedge clk_i);
    start_i = 1; comm_len_i = 8'd7; comp_len_i = 8'd1;
    @(negedge clk_i);
    start_i = 0;
    finish_run(16);

    // R6 abort during computation, then clean restart
    cf = '{900, 900, -900, 450};
    fill_lcg(3);
    start_run(2, 3);
    while (idx < 6) @(negedge clk_i);
    while (phase_o != 2'd2) @(negedge clk_i);
    abort_i = 1;
    @(negedge clk_i);
    abort_i = 0;
    chk(phase_o == 2'd0, "R6 idle after mid abort", phase_o, 0);
    chk(!result_valid_o, "R6 valid after mid abort", result_valid_o, 0);
    expq.delete();
    repeat (5) @(negedge clk_i);
    fill_lcg(41);
    start_run(2, 3);
    finish_run(10);

    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end
endmodule